// File: doc/BRIEF.md
# Drawing Engine Status and Background Colour Registers

This unit is the register-access face of a 2D drawing engine. It holds the background colour used for pattern expansion, lines and solid fills, and it assembles a read-only status word from the activity signals that the rest of the engine drives. These signals are BLT and vector progress, host FIFO fill state, outstanding memory writes and the outgoing interrupt line. Software reaches both through a single-cycle 32-bit request port. Each request is acknowledged exactly one cycle later, so no access ever stalls.

The colour register stores whatever is written to it. Its readback depends on the current pixel depth. At 8 bpp the low byte is copied to every lane, and at 16 bpp the low half is copied to the upper half. At 32 bpp, and for the unused depth code, the stored word is returned as written.

A configuration input chooses between two meanings of "busy":
- **Fine-grained mode:** busy is the OR of the live activity sources.
- **Span mode:** an explicit tracker with three states is used.
  - `SPAN_IDLE` moves to `SPAN_RUN` on a BLT or vector start.
  - `SPAN_RUN` moves to `SPAN_IDLE` when the operation, the memory writes and the FIFO are all finished. It moves to `SPAN_DRAIN` when only the operation has ended.
  - `SPAN_DRAIN` moves to `SPAN_IDLE` once everything is finished, and back to `SPAN_RUN` on a new start.

The access port has its own two-state machine, `ACC_IDLE` and `ACC_ACK`. A request moves it to `ACC_ACK`, and with no request it returns to `ACC_IDLE`.

Top module: `drw_status_unit`

## Requirements
- R1: After reset, the background colour reads as zero, the status busy bit (bit 8) reads 0 and the done bit (bit 9) reads 1.
- R2: With `pix_depth` = 0 (8 bpp), a colour read returns bits [7:0] of the stored value in all four byte lanes.
- R3: With `pix_depth` = 1 (16 bpp), a colour read returns bits [15:0] of the stored value in both halves.
- R4: With `pix_depth` = 2 or 3 (32 bpp), a colour read returns the stored 32-bit value unchanged.
- R5: The colour register changes only on a write to word address 0. A write to the status address (1) changes nothing that can be read, and engine activity never alters the colour.
- R6: The status word (word address 1) has the following layout, and every other bit reads 0:
  - bit 0: `blt_active`
  - bit 1: `vec_active`
  - bit 2: `hfifo_full`
  - bit 3: `hfifo_not_empty`
  - bit 8: busy
  - bit 9: done
  - bit 10: interrupt
- R7: In every status read, bit 9 is the complement of bit 8.
- R8: With `cfg_fine_busy` = 1, busy is 1 whenever any of the following holds: a register access was acknowledged in the previous cycle, the host FIFO is non-empty, a BLT or vector is active, or a memory write is pending.
- R9: With `cfg_fine_busy` = 0, busy rises in the cycle after a `blt_start` or `vec_start` pulse.
- R10: With `cfg_fine_busy` = 0, busy falls only after a cycle with no start, no active BLT or vector, no pending memory write and an empty FIFO. A start that arrives in that same cycle keeps busy at 1.
- R11: Status bit 10 equals `irq_in` as sampled in the request cycle.
- R12: Every request is acknowledged with `reg_ack` = 1 in the next cycle, whether it is a read or a write. `reg_rdata` is valid in that cycle and reflects the inputs sampled in the request cycle. Reads of any other word address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Access request, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (4) | Word address: 0 colour, 1 status |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, valid with `reg_ack` |
| reg_ack | output | 1 | Access completion, one cycle after request |
| pix_depth | input | 2 | 0 = 8 bpp, 1 = 16 bpp, 2/3 = 32 bpp |
| cfg_fine_busy | input | 1 | 1 = fine-grained busy, 0 = span busy |
| blt_start | input | 1 | BLT start pulse |
| vec_start | input | 1 | Vector start pulse |
| blt_active | input | 1 | BLT in progress |
| vec_active | input | 1 | Vector in progress |
| hfifo_full | input | 1 | Host FIFO full |
| hfifo_not_empty | input | 1 | Host FIFO holds entries |
| mem_wr_pending | input | 1 | Memory write outstanding |
| irq_in | input | 1 | Engine interrupt line |

## Verification
The bench builds the unit at its defaults: a 32-bit data path, 4-bit word addresses, colour at address 0 and status at address 1. With four byte lanes, the 16 bpp case copies a two-lane pair, which makes the lane-index arithmetic observable. The 4-bit address also leaves room to probe an unmapped address. A behavioural model runs alongside the unit: a colour word, a span flag and the previous-cycle acknowledge. It drives each busy source in isolation and, in span mode, walks through run, drain, re-start and same-cycle start-at-completion.

// File: rtl/drw_stat_pkg.sv
package drw_stat_pkg;

    // Status word bit positions; software decodes these.
    localparam int unsigned ST_BLT_BIT   = 0;
    localparam int unsigned ST_VEC_BIT   = 1;
    localparam int unsigned ST_FULL_BIT  = 2;
    localparam int unsigned ST_NEMPT_BIT = 3;
    localparam int unsigned ST_BUSY_BIT  = 8;
    localparam int unsigned ST_DONE_BIT  = 9;
    localparam int unsigned ST_IRQ_BIT   = 10;

    // Pixel depth codes.
    localparam logic [1:0] DEPTH_8  = 2'd0;
    localparam logic [1:0] DEPTH_16 = 2'd1;

    typedef enum logic [1:0] {
        SPAN_IDLE  = 2'd0,
        SPAN_RUN   = 2'd1,
        SPAN_DRAIN = 2'd2
    } span_state_e;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_ACK  = 1'b1
    } acc_state_e;

endpackage

// File: rtl/drw_color_reg.sv
module drw_color_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        depth,
    output logic [DATA_W-1:0] rd_color
);
    import drw_stat_pkg::*;

    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = DATA_W / LANE_W;

    logic [DATA_W-1:0] color_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            color_q <= '0;
        else if (wr_en)
            color_q <= wr_data;
    end

    // Per-lane readback selection by pixel depth.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] lane_v;
        always_comb begin
            if (depth == DEPTH_8)
                lane_v = color_q[LANE_W-1:0];
            else if (depth == DEPTH_16)
                lane_v = color_q[(i % 2)*LANE_W +: LANE_W];
            else
                lane_v = color_q[i*LANE_W +: LANE_W];
        end
        assign rd_color[i*LANE_W +: LANE_W] = lane_v;
    end

    // R5: without a write strobe the stored colour holds.
    p_color_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(color_q));

    // R5: a write strobe loads the data.
    p_color_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> color_q == $past(wr_data));

endmodule

// File: rtl/drw_busy_track.sv
module drw_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic fine_mode,
    input  logic acc_pending,
    input  logic op_start,
    input  logic blt_active,
    input  logic vec_active,
    input  logic fifo_not_empty,
    input  logic wr_pending,
    output logic busy
);
    import drw_stat_pkg::*;

    span_state_e state_q, state_d;
    logic        ops_idle;
    logic        drained;
    logic        fine_busy;

    assign ops_idle = !blt_active && !vec_active;
    assign drained  = !wr_pending && !fifo_not_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SPAN_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SPAN_IDLE: begin
                if (op_start)
                    state_d = SPAN_RUN;
            end
            SPAN_RUN: begin
                if (op_start)
                    state_d = SPAN_RUN;
                else if (ops_idle && drained)
                    state_d = SPAN_IDLE;
                else if (ops_idle)
                    state_d = SPAN_DRAIN;
            end
            SPAN_DRAIN: begin
                if (op_start)
                    state_d = SPAN_RUN;
                else if (ops_idle && drained)
                    state_d = SPAN_IDLE;
            end
            default: state_d = SPAN_IDLE;
        endcase
    end

    assign fine_busy = acc_pending || fifo_not_empty || blt_active ||
                       vec_active || wr_pending;

    always_comb begin
        if (fine_mode)
            busy = fine_busy;
        else
            busy = (state_q != SPAN_IDLE);
    end

    // R9: a start always leaves the tracker non-idle.
    p_span_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> state_q != SPAN_IDLE);

    // R10: while writes or FIFO work remain, the span cannot close.
    p_span_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SPAN_IDLE && !drained) |=> state_q != SPAN_IDLE);

    // R10: idle with no start stays idle.
    p_span_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SPAN_IDLE && !op_start) |=> state_q == SPAN_IDLE);

endmodule

// File: rtl/drw_reg_port.sv
module drw_reg_port #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned COLOR_ADDR  = 0,
    parameter int unsigned STATUS_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] color_rd,
    input  logic [DATA_W-1:0] status_rd,
    output logic              color_wr_en,
    output logic              ack,
    output logic              rd_status,
    output logic [DATA_W-1:0] rdata
);
    import drw_stat_pkg::*;

    localparam logic [ADDR_W-1:0] A_COLOR  = ADDR_W'(COLOR_ADDR);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);

    acc_state_e        state_q, state_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic              rd_status_q;

    always_comb begin
        unique case (state_q)
            ACC_IDLE: state_d = req ? ACC_ACK : ACC_IDLE;
            ACC_ACK:  state_d = req ? ACC_ACK : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    always_comb begin
        rdata_d = '0;
        if (req && !we) begin
            if (addr == A_COLOR)
                rdata_d = color_rd;
            else if (addr == A_STATUS)
                rdata_d = status_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ACC_IDLE;
            rdata_q     <= '0;
            rd_status_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            rdata_q     <= rdata_d;
            rd_status_q <= req && !we && (addr == A_STATUS);
        end
    end

    assign color_wr_en = req && we && (addr == A_COLOR);
    assign ack         = (state_q == ACC_ACK);
    assign rd_status   = rd_status_q;
    assign rdata       = rdata_q;

    // R12: every request completes in the following cycle.
    p_ack_after_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ack);

    // R12: no completion without a request.
    p_no_stray_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ack);

endmodule

// File: rtl/drw_status_unit.sv
module drw_status_unit #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned COLOR_ADDR  = 0,
    parameter int unsigned STATUS_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_ack,
    input  logic [1:0]        pix_depth,
    input  logic              cfg_fine_busy,
    input  logic              blt_start,
    input  logic              vec_start,
    input  logic              blt_active,
    input  logic              vec_active,
    input  logic              hfifo_full,
    input  logic              hfifo_not_empty,
    input  logic              mem_wr_pending,
    input  logic              irq_in
);
    import drw_stat_pkg::*;

    logic [DATA_W-1:0] color_rd;
    logic [DATA_W-1:0] status_word;
    logic              color_wr_en;
    logic              busy;
    logic              rd_status;

    drw_color_reg #(.DATA_W(DATA_W)) u_color (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (color_wr_en),
        .wr_data  (reg_wdata),
        .depth    (pix_depth),
        .rd_color (color_rd)
    );

    drw_busy_track u_busy (
        .clk            (clk),
        .rst_n          (rst_n),
        .fine_mode      (cfg_fine_busy),
        .acc_pending    (reg_ack),
        .op_start       (blt_start || vec_start),
        .blt_active     (blt_active),
        .vec_active     (vec_active),
        .fifo_not_empty (hfifo_not_empty),
        .wr_pending     (mem_wr_pending),
        .busy           (busy)
    );

    always_comb begin
        status_word               = '0;
        status_word[ST_BLT_BIT]   = blt_active;
        status_word[ST_VEC_BIT]   = vec_active;
        status_word[ST_FULL_BIT]  = hfifo_full;
        status_word[ST_NEMPT_BIT] = hfifo_not_empty;
        status_word[ST_BUSY_BIT]  = busy;
        status_word[ST_DONE_BIT]  = !busy;
        status_word[ST_IRQ_BIT]   = irq_in;
    end

    drw_reg_port #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .COLOR_ADDR  (COLOR_ADDR),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (reg_req),
        .we          (reg_we),
        .addr        (reg_addr),
        .color_rd    (color_rd),
        .status_rd   (status_word),
        .color_wr_en (color_wr_en),
        .ack         (reg_ack),
        .rd_status   (rd_status),
        .rdata       (reg_rdata)
    );

    // R7: done and busy in a returned status word are complementary.
    p_done_compl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ack && rd_status) |-> reg_rdata[ST_DONE_BIT] != reg_rdata[ST_BUSY_BIT]);

    // R11: the interrupt bit reflects the line at request time.
    p_irq_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ack && rd_status) |-> reg_rdata[ST_IRQ_BIT] == $past(irq_in));

    // R6: reserved status bits read as zero.
    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ack && rd_status) |-> (reg_rdata[7:4] == 4'h0 &&
                                    reg_rdata[DATA_W-1:ST_IRQ_BIT+1] == '0));

endmodule

// File: tb/drw_status_unit_test.sv
module drw_status_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ack;
    logic [1:0]  pix_depth = 2'd2;
    logic        cfg_fine_busy = 1'b0;
    logic        blt_start = 0, vec_start = 0, blt_active = 0, vec_active = 0;
    logic        hfifo_full = 0, hfifo_not_empty = 0, mem_wr_pending = 0, irq_in = 0;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string tag = "R1";

    // Reference model state.
    logic [31:0] m_color = '0;
    logic        m_span = 1'b0;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = '0;

    always #5 clk = ~clk;

    drw_status_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ack(reg_ack), .pix_depth(pix_depth), .cfg_fine_busy(cfg_fine_busy),
        .blt_start(blt_start), .vec_start(vec_start), .blt_active(blt_active),
        .vec_active(vec_active), .hfifo_full(hfifo_full),
        .hfifo_not_empty(hfifo_not_empty), .mem_wr_pending(mem_wr_pending),
        .irq_in(irq_in)
    );

    function automatic logic [31:0] color_view(logic [31:0] c, logic [1:0] d);
        if (d == 2'd0) return {4{c[7:0]}};
        if (d == 2'd1) return {2{c[15:0]}};
        return c;
    endfunction

    // Model: update on each rising edge from the inputs settled before it.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_color = '0; m_span = 0; m_ack = 0; m_rdata = '0;
        end else begin
            logic        bsy;
            logic [31:0] st;
            bsy = cfg_fine_busy ? (m_ack | hfifo_not_empty | blt_active |
                                   vec_active | mem_wr_pending) : m_span;
            st = 32'h0;
            st[0] = blt_active; st[1] = vec_active; st[2] = hfifo_full;
            st[3] = hfifo_not_empty; st[8] = bsy; st[9] = ~bsy; st[10] = irq_in;
            m_rdata = 32'h0;
            if (reg_req && !reg_we) begin
                if (reg_addr == 4'd0) m_rdata = color_view(m_color, pix_depth);
                else if (reg_addr == 4'd1) m_rdata = st;
            end
            if (reg_req && reg_we && reg_addr == 4'd0) m_color = reg_wdata;
            if (blt_start || vec_start) m_span = 1'b1;
            else if (!blt_active && !vec_active && !mem_wr_pending && !hfifo_not_empty)
                m_span = 1'b0;
            m_ack = reg_req;
        end
    end

    // Compare on every falling edge after reset.
    always @(negedge clk) begin
        if (rst_n) begin
            compared++;
            if (reg_ack !== m_ack) begin
                mismatched++;
                $display("FAIL %s (R12 ack): actual %0b expected %0b", tag, reg_ack, m_ack);
            end
            if (m_ack) begin
                compared++;
                if (reg_rdata !== m_rdata) begin
                    mismatched++;
                    $display("FAIL %s rdata: actual %08h expected %08h", tag, reg_rdata, m_rdata);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic access(input logic we, input logic [3:0] a, input logic [31:0] d);
        reg_req = 1; reg_we = we; reg_addr = a; reg_wdata = d;
        tick();
        reg_req = 0; reg_we = 0;
        tick();
    endtask

    task automatic rd(input logic [3:0] a);
        access(1'b0, a, 32'h0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1; tick();
        // R1: reset values.
        tag = "R1"; rd(4'd0); rd(4'd1);

        // R2 / R3 / R4: depth replication.
        access(1'b1, 4'd0, 32'hA1B2C3D4);
        tag = "R2"; pix_depth = 2'd0; rd(4'd0);
        tag = "R3"; pix_depth = 2'd1; rd(4'd0);
        tag = "R4"; pix_depth = 2'd2; rd(4'd0);
        pix_depth = 2'd3; rd(4'd0);
        access(1'b1, 4'd0, 32'h0000_5A3C);
        tag = "R2"; pix_depth = 2'd0; rd(4'd0);
        tag = "R3"; pix_depth = 2'd1; rd(4'd0);
        pix_depth = 2'd2;

        // R5: status writes ignored, activity leaves colour intact.
        tag = "R5";
        access(1'b1, 4'd1, 32'hFFFF_FFFF);
        rd(4'd0); rd(4'd1);
        blt_start = 1; blt_active = 1; tick(); blt_start = 0;
        rd(4'd0);
        blt_active = 0; tick(); tick();
        rd(4'd0);
        tag = "R12"; rd(4'd7); access(1'b1, 4'd9, 32'h1234_5678); rd(4'd0);

        // R6 / R7: layout of status with various patterns (fine mode).
        cfg_fine_busy = 1;
        tag = "R6"; hfifo_full = 1; hfifo_not_empty = 1; rd(4'd1);
        hfifo_full = 0; hfifo_not_empty = 0; vec_active = 1; rd(4'd1);
        vec_active = 0; tag = "R7"; rd(4'd1);

        // R8: each fine busy source alone.
        tag = "R8";
        hfifo_not_empty = 1; rd(4'd1); hfifo_not_empty = 0;
        blt_active = 1; rd(4'd1); blt_active = 0;
        vec_active = 1; rd(4'd1); vec_active = 0;
        mem_wr_pending = 1; rd(4'd1); mem_wr_pending = 0;
        rd(4'd1);
        // Back-to-back reads: second sees the pending access.
        reg_req = 1; reg_we = 0; reg_addr = 4'd1; tick(); tick();
        reg_req = 0; tick(); tick();

        // R9 / R10: span mode.
        cfg_fine_busy = 0;
        tag = "R9";
        blt_start = 1; tick(); blt_start = 0; blt_active = 1;
        rd(4'd1);
        tag = "R10";
        blt_active = 0; mem_wr_pending = 1; tick();
        rd(4'd1);
        mem_wr_pending = 0; hfifo_not_empty = 1; rd(4'd1);
        // Start in the very cycle the completion conditions are met.
        hfifo_not_empty = 0; vec_start = 1; tick(); vec_start = 0;
        rd(4'd1);
        tick(); rd(4'd1);
        // Restart from drain.
        vec_start = 1; tick(); vec_start = 0; vec_active = 1; tick();
        vec_active = 0; mem_wr_pending = 1; tick();
        blt_start = 1; tick(); blt_start = 0; mem_wr_pending = 0; tick();
        rd(4'd1); tick(); rd(4'd1);

        // R11: interrupt mirror.
        tag = "R11"; irq_in = 1; rd(4'd1); irq_in = 0; rd(4'd1);
        tick(); tick();
        finish_run();
    end

endmodule